// File: doc/BRIEF.md
# Debug Register Access Guard

This block holds a processor's debug register set. It has four breakpoint address registers, a debug status register and a debug control register. A register-move port lets software read or write any of eight indices. Bit 13 of the control register is a guard bit. While the guard bit is set, every access on that port is refused. A refused access raises a one-cycle debug exception request and records the refusal in the status register.

The exception logic outside this block signals entry into the debug handler with a single-cycle strobe. The strobe carries a vector of pending debug events, already computed elsewhere (address hits, single step and similar). On entry the block merges those events into the status register under fixed keep and accept masks. It also drops the guard bit, whatever caused the exception, so the handler can then read and write the registers freely. An access that arrives in the same cycle as an entry strobe is held for one cycle. It is then replayed against the updated guard bit.

Top module: `dbgreg_guard`

## Requirements
- R1: After synchronous reset the status register reads 0xFFFF0FF0, the control register reads 0x00000400, all four breakpoint registers read zero, and rd_valid and exc_req are low.
- R2: An unguarded write lands at the clock edge where it is presented. Indices 0 to 3 select breakpoint registers 0 to 3, indices 4 and 6 select the status register, and indices 5 and 7 select the control register.
- R3: An unguarded read raises rd_valid for one cycle after the edge where it is presented, with rd_data holding the selected register. Reads use the same index aliasing as writes.
- R4: While control bit 13 is set, any access is refused. At the next edge exc_req rises and exc_cause = {write flag, index}, where bit 3 is the write flag and bits 2:0 are the index. rd_valid stays low.
- R5: A refused access changes no breakpoint or control register. Its only effect on the status register is that status bit 13 becomes 1.
- R6: On an entry strobe the status register becomes (status AND 0xFFFF6FF0) OR (events AND 0x0000E00F).
- R7: Every entry strobe clears control bit 13, whatever the events. Accesses made after the entry are not refused, so one watchpoint exception produces exactly one exception entry.
- R8: Status bits 14 and 13 survive entry strobes and are cleared only by a software write to the status register.
- R9: An access presented in the same cycle as an entry strobe has no effect at that edge. It is replayed at the next edge against the post-entry guard bit. An access offered during that replay cycle is dropped.
- R10: exc_req and rd_valid are never high together. exc_req falls after one cycle when no further refused access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register-move request present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 3 | Debug register index 0..7 |
| acc_wdata | input | 32 | Write data |
| entry_stb | input | 1 | Debug handler entry strobe |
| entry_events | input | 32 | Pending debug event bits merged on entry |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| exc_req | output | 1 | Debug exception request pulse from a refused access |
| exc_cause | output | 4 | {write flag, index} of the refused access |
| dbg_status | output | 32 | Current status register |
| dbg_ctrl | output | 32 | Current control register |

## Verification
The bench sets the guard bit and then attempts a write. A later read after handler entry must return the original breakpoint value. A design that let the blocked write through would return the new value instead. It raises an entry strobe whose events do not include a guard violation and expects the guard bit to be clear afterwards. A design that cleared the guard bit only for guard-caused exceptions would keep trapping the handler's reads. It presents an access together with an entry strobe and expects nothing on that edge, followed by a clean replay. A design that evaluated the access against the old guard bit would raise a spurious exception. Finally it drives all-ones events to expose any wrong keep or accept mask bits, and it checks that status bits 14 and 13 survive entry but give way to a software write.

// File: rtl/dbg_guard_pkg.sv
package dbg_guard_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_DEFER,
    ACT_BLOCK,
    ACT_READ,
    ACT_WRITE
  } act_e;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;
  } acc_t;
endpackage

// File: rtl/dbg_acc_arbiter.sv
// Chooses the access to act on this cycle and classifies it.
// An access that meets an entry strobe is parked for one cycle and replayed.
module dbg_acc_arbiter
  import dbg_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  acc_t req,
  input  logic entry_stb,
  input  logic guard_on,
  output acc_t eff,
  output act_e act,
  output logic defer_pending
);
  acc_t held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (eff.valid && entry_stb) begin
      held_q <= eff;
    end else begin
      held_q <= '0;
    end
  end

  assign defer_pending = held_q.valid;
  // The parked access wins; a fresh request in the replay cycle is dropped.
  assign eff = held_q.valid ? held_q : req;

  always_comb begin
    act = ACT_NONE;
    if (eff.valid) begin
      if (entry_stb)      act = ACT_DEFER;
      else if (guard_on)  act = ACT_BLOCK;
      else if (eff.write) act = ACT_WRITE;
      else                act = ACT_READ;
    end
  end
endmodule

// File: rtl/dbg_bkpt_file.sv
// Breakpoint address registers: one write port, one asynchronous read port.
module dbg_bkpt_file #(
  parameter int unsigned NUM_BKPT = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned SEL_W   = (NUM_BKPT > 1) ? $clog2(NUM_BKPT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] bank [NUM_BKPT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BKPT; i++) begin
      if (rst) begin
        bank[i] <= '0;
      end else if (wr_en && wr_sel == SEL_W'(i)) begin
        bank[i] <= wr_data;
      end
    end
  end

  assign rd_data = bank[rd_sel];
endmodule

// File: rtl/dbg_stat_ctrl.sv
// Status and control registers: entry commit, refusal flag, software writes.
module dbg_stat_ctrl #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GD_BIT   = 13,
  parameter int unsigned BD_BIT   = 13,
  parameter logic [DATA_W-1:0] KEEP_MASK = 32'hFFFF_6FF0,
  parameter logic [DATA_W-1:0] EVT_MASK  = 32'h0000_E00F,
  parameter logic [DATA_W-1:0] STAT_RST  = 32'hFFFF_0FF0,
  parameter logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              entry_stb,
  input  logic [DATA_W-1:0] entry_events,
  input  logic              block_hit,
  input  logic              sw_wr_stat,
  input  logic              sw_wr_ctrl,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              guard_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_RST;
      ctrl_q <= CTRL_RST;
    end else if (entry_stb) begin
      stat_q         <= (stat_q & KEEP_MASK) | (entry_events & EVT_MASK);
      ctrl_q[GD_BIT] <= 1'b0;
    end else begin
      if (block_hit)  stat_q[BD_BIT] <= 1'b1;
      if (sw_wr_stat) stat_q <= sw_wdata;
      if (sw_wr_ctrl) ctrl_q <= sw_wdata;
    end
  end

  assign guard_on = ctrl_q[GD_BIT];
endmodule

// File: rtl/dbgreg_guard.sv
module dbgreg_guard
  import dbg_guard_pkg::*;
#(
  parameter int unsigned NUM_BKPT = 4,
  parameter int unsigned GD_BIT   = 13,
  parameter int unsigned BD_BIT   = 13,
  parameter logic [DATA_W-1:0] KEEP_MASK = 32'hFFFF_6FF0,
  parameter logic [DATA_W-1:0] EVT_MASK  = 32'h0000_E00F,
  parameter logic [DATA_W-1:0] STAT_RST  = 32'hFFFF_0FF0,
  parameter logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0400,
  localparam int unsigned SEL_W = (NUM_BKPT > 1) ? $clog2(NUM_BKPT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              entry_stb,
  input  logic [DATA_W-1:0] entry_events,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              exc_req,
  output logic [IDX_W:0]    exc_cause,
  output logic [DATA_W-1:0] dbg_status,
  output logic [DATA_W-1:0] dbg_ctrl
);
  acc_t              req, eff;
  act_e              act;
  logic              defer_pending;
  logic              guard_on;
  logic              is_bkpt, is_ctrl;
  logic              block_hit;
  logic [DATA_W-1:0] bk_rd, rd_mux;

  assign req = '{valid: acc_valid, write: acc_write, idx: acc_idx, wdata: acc_wdata};

  dbg_acc_arbiter u_arb (
    .clk           (clk),
    .rst           (rst),
    .req           (req),
    .entry_stb     (entry_stb),
    .guard_on      (guard_on),
    .eff           (eff),
    .act           (act),
    .defer_pending (defer_pending)
  );

  // Index decode: low indices hit breakpoints, the rest alternate status/control.
  assign is_bkpt   = eff.idx < IDX_W'(NUM_BKPT);
  assign is_ctrl   = !is_bkpt && eff.idx[0];
  assign block_hit = (act == ACT_BLOCK);

  dbg_bkpt_file #(
    .NUM_BKPT (NUM_BKPT),
    .DATA_W   (DATA_W)
  ) u_bkpt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   ((act == ACT_WRITE) && is_bkpt),
    .wr_sel  (eff.idx[SEL_W-1:0]),
    .wr_data (eff.wdata),
    .rd_sel  (eff.idx[SEL_W-1:0]),
    .rd_data (bk_rd)
  );

  dbg_stat_ctrl #(
    .DATA_W    (DATA_W),
    .GD_BIT    (GD_BIT),
    .BD_BIT    (BD_BIT),
    .KEEP_MASK (KEEP_MASK),
    .EVT_MASK  (EVT_MASK),
    .STAT_RST  (STAT_RST),
    .CTRL_RST  (CTRL_RST)
  ) u_sc (
    .clk          (clk),
    .rst          (rst),
    .entry_stb    (entry_stb),
    .entry_events (entry_events),
    .block_hit    (block_hit),
    .sw_wr_stat   ((act == ACT_WRITE) && !is_bkpt && !is_ctrl),
    .sw_wr_ctrl   ((act == ACT_WRITE) && is_ctrl),
    .sw_wdata     (eff.wdata),
    .stat_q       (dbg_status),
    .ctrl_q       (dbg_ctrl),
    .guard_on     (guard_on)
  );

  assign rd_mux = is_bkpt ? bk_rd : (is_ctrl ? dbg_ctrl : dbg_status);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      exc_req   <= 1'b0;
      exc_cause <= '0;
    end else begin
      rd_valid <= (act == ACT_READ);
      exc_req  <= block_hit;
      if (act == ACT_READ) rd_data   <= rd_mux;
      if (block_hit)       exc_cause <= {eff.write, eff.idx};
    end
  end
endmodule

// File: rtl/dbgreg_guard_chk.sv
module dbgreg_guard_chk #(
  parameter int unsigned GD_BIT = 13,
  parameter int unsigned BD_BIT = 13,
  parameter logic [31:0] KEEP_MASK = 32'hFFFF_6FF0,
  parameter logic [31:0] EVT_MASK  = 32'h0000_E00F
) (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic        entry_stb,
  input logic [31:0] entry_events,
  input logic        defer_pending,
  input logic        rd_valid,
  input logic        exc_req,
  input logic [31:0] dbg_status,
  input logic [31:0] dbg_ctrl
);
  // R4
  refused_raises_exc_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !entry_stb && !defer_pending && dbg_ctrl[GD_BIT]) |=> (exc_req && !rd_valid));

  // R5
  refused_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !entry_stb && !defer_pending && dbg_ctrl[GD_BIT]) |=> ($stable(dbg_ctrl) && dbg_status[BD_BIT]));

  // R6
  entry_merge_chk: assert property (@(posedge clk) disable iff (rst)
    entry_stb |=> (dbg_status == (($past(dbg_status) & KEEP_MASK) | ($past(entry_events) & EVT_MASK))));

  // R7
  entry_drops_guard_chk: assert property (@(posedge clk) disable iff (rst)
    entry_stb |=> !dbg_ctrl[GD_BIT]);

  // R8
  entry_keeps_bs_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && dbg_status[14]) |=> dbg_status[14]);

  // R9
  coincident_defers_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && entry_stb) |=> (!exc_req && !rd_valid));

  // R10
  exc_rd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> !rd_valid);
endmodule

bind dbgreg_guard dbgreg_guard_chk #(
  .GD_BIT    (GD_BIT),
  .BD_BIT    (BD_BIT),
  .KEEP_MASK (KEEP_MASK),
  .EVT_MASK  (EVT_MASK)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .entry_stb     (entry_stb),
  .entry_events  (entry_events),
  .defer_pending (defer_pending),
  .rd_valid      (rd_valid),
  .exc_req       (exc_req),
  .dbg_status    (dbg_status),
  .dbg_ctrl      (dbg_ctrl)
);

// File: tb/dbgreg_guard_tb.sv
`timescale 1ns/1ps
module dbgreg_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_idx = '0;
  logic [31:0] acc_wdata = '0;
  logic        entry_stb = 1'b0;
  logic [31:0] entry_events = '0;
  logic        rd_valid, exc_req;
  logic [31:0] rd_data, dbg_status, dbg_ctrl;
  logic [3:0]  exc_cause;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbgreg_guard u_dut (
    .clk (clk), .rst (rst),
    .acc_valid (acc_valid), .acc_write (acc_write), .acc_idx (acc_idx), .acc_wdata (acc_wdata),
    .entry_stb (entry_stb), .entry_events (entry_events),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .exc_req (exc_req), .exc_cause (exc_cause),
    .dbg_status (dbg_status), .dbg_ctrl (dbg_ctrl)
  );

  // {write, idx[2:0], wdata[31:0], exp_rd_valid, exp_rd_data[31:0], exp_exc}
  localparam logic [69:0] VEC [12] = '{
    {1'b1, 3'd0, 32'h1111_0000, 1'b0, 32'h0,          1'b0},
    {1'b1, 3'd1, 32'h2222_0004, 1'b0, 32'h0,          1'b0},
    {1'b1, 3'd2, 32'h3333_0008, 1'b0, 32'h0,          1'b0},
    {1'b1, 3'd3, 32'h4444_000C, 1'b0, 32'h0,          1'b0},
    {1'b0, 3'd0, 32'h0,         1'b1, 32'h1111_0000, 1'b0},
    {1'b0, 3'd3, 32'h0,         1'b1, 32'h4444_000C, 1'b0},
    {1'b0, 3'd5, 32'h0,         1'b1, 32'h0000_0400, 1'b0},
    {1'b0, 3'd4, 32'h0,         1'b1, 32'hFFFF_0FF0, 1'b0},
    {1'b1, 3'd6, 32'h0000_4001, 1'b0, 32'h0,          1'b0},
    {1'b0, 3'd4, 32'h0,         1'b1, 32'h0000_4001, 1'b0},
    {1'b1, 3'd7, 32'h0000_0500, 1'b0, 32'h0,          1'b0},
    {1'b0, 3'd5, 32'h0,         1'b1, 32'h0000_0500, 1'b0}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one cycle of stimulus; return at the following negedge.
  task automatic step(input logic v, input logic w, input logic [2:0] idx, input logic [31:0] d,
                      input logic stb, input logic [31:0] ev);
    acc_valid = v; acc_write = w; acc_idx = idx; acc_wdata = d;
    entry_stb = stb; entry_events = ev;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; entry_stb = 1'b0; entry_events = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "rd_valid", {31'b0, rd_valid}, 32'h0);
    check("R1", "exc_req", {31'b0, exc_req}, 32'h0);
    check("R1", "status", dbg_status, 32'hFFFF_0FF0);
    check("R1", "ctrl", dbg_ctrl, 32'h0000_0400);
    step(1, 0, 3'd1, 0, 0, 0);
    check("R1", "bkpt1", rd_data, 32'h0);

    // R2 / R3 vector table
    for (int i = 0; i < 12; i++) begin
      logic [69:0] v;
      string rq;
      v = VEC[i];
      rq = v[69] ? "R2" : "R3";
      step(1, v[69], v[68:66], v[65:34], 0, 0);
      check(rq, "rd_valid", {31'b0, rd_valid}, {31'b0, v[33]});
      check(rq, "exc_req", {31'b0, exc_req}, {31'b0, v[0]});
      if (v[33]) check(rq, "rd_data", rd_data, v[32:1]);
    end

    // Arm the guard
    step(1, 1, 3'd5, 32'h0000_2500, 0, 0);
    check("R2", "ctrl arm", dbg_ctrl, 32'h0000_2500);

    // R4 refused read
    step(1, 0, 3'd2, 0, 0, 0);
    check("R4", "exc_req read", {31'b0, exc_req}, 32'h1);
    check("R4", "cause read", {28'b0, exc_cause}, 32'h2);
    check("R4", "rd_valid refused", {31'b0, rd_valid}, 32'h0);
    check("R5", "status BD set", dbg_status, 32'h0000_6001);
    // R10 pulse ends
    step(0, 0, 0, 0, 0, 0);
    check("R10", "exc_req falls", {31'b0, exc_req}, 32'h0);

    // R4 / R5 refused write
    step(1, 1, 3'd0, 32'hDEAD_BEEF, 0, 0);
    check("R4", "cause write", {28'b0, exc_cause}, 32'h8);
    check("R5", "ctrl unchanged", dbg_ctrl, 32'h0000_2500);

    // R6 / R7 / R8 entry for a watchpoint event, not a guard event
    step(0, 0, 0, 0, 1, 32'h0000_0002);
    check("R6", "status merge", dbg_status, 32'h0000_6002);
    check("R7", "guard cleared", dbg_ctrl, 32'h0000_0500);
    step(1, 0, 3'd0, 0, 0, 0);
    check("R7", "handler read no trap", {31'b0, exc_req}, 32'h0);
    check("R5", "bkpt0 untouched", rd_data, 32'h1111_0000);

    // R9 access coincident with entry
    step(1, 1, 3'd7, 32'h0000_2500, 0, 0);
    step(1, 0, 3'd3, 0, 1, 32'h0);
    check("R9", "no rd same edge", {31'b0, rd_valid}, 32'h0);
    check("R9", "no exc same edge", {31'b0, exc_req}, 32'h0);
    check("R8", "BS BD kept", dbg_status, 32'h0000_6000);
    step(0, 0, 0, 0, 0, 0);
    check("R9", "replay rd_valid", {31'b0, rd_valid}, 32'h1);
    check("R9", "replay data", rd_data, 32'h4444_000C);
    check("R9", "replay no exc", {31'b0, exc_req}, 32'h0);

    // R6 all-ones events exposes the masks
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    check("R6", "all-ones events", dbg_status, 32'h0000_E00F);

    // R8 software write clears, entry leaves zero
    step(1, 1, 3'd4, 32'h0, 0, 0);
    check("R8", "sw clear", dbg_status, 32'h0);
    step(0, 0, 0, 0, 1, 32'h0);
    check("R8", "stays clear", dbg_status, 32'h0);

    // R9 access during replay cycle is dropped
    step(1, 1, 3'd5, 32'h0000_2500, 0, 0);
    step(1, 0, 3'd1, 0, 1, 32'h0);
    step(1, 1, 3'd1, 32'h0000_0009, 0, 0);
    check("R9", "replay read", rd_data, 32'h2222_0004);
    step(1, 0, 3'd1, 0, 0, 0);
    check("R9", "dropped write", rd_data, 32'h2222_0004);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule